// File: doc/BRIEF.md
# Bit-band alias bridge

This bridge sits between a simple request/response slave port and a memory master port. Every 32-bit word of a 32 MiB alias window stands for one bit of a 1 MiB target region of real memory. A read of an alias word returns that single bit in bit 0 of the response. A write sets or clears that bit with a read-modify-write on the downstream port. There are two alias windows, told apart by request address bit 30. The window with bit 30 clear (0x2200_0000) targets base 0x2000_0000. The window with bit 30 set (0x4200_0000) targets base 0x4000_0000. Decoding which requests reach the bridge is left to the fabric.

A state machine sequences each access:
- IDLE accepts a request while `req_ready` is high.
- IDLE goes to READ for a legal size, or straight to RESPOND for an illegal one.
- READ issues the downstream read. On completion it goes to RESPOND after a read or after an error. It goes to WBACK after an error-free read that belongs to a write.
- WBACK issues the write-back and goes to RESPOND when it completes.
- RESPOND drives a one-cycle response and returns to IDLE.

The downstream port holds `mem_req` and its fields steady until a one-cycle `mem_done`. `mem_rdata` and `mem_error` are valid alongside `mem_done`.

Top module: `bitband_bridge`

## Requirements
- R1: The downstream address is the window base OR'ed with request address bits 24:0 shifted right by 5, then aligned down to a multiple of the access size. The base is 0x2000_0000 when request bit 30 is 0 and 0x4000_0000 when it is 1.
- R2: `req_size` holds the byte count, and 1, 2 and 4 are legal. The downstream access uses the same size.
- R3: A read issues exactly one downstream read and no write. Its response data carries the selected bit in bit 0 and zero in every other bit.
- R4: A write first reads, then writes back to the same address with the same size. The write-back data is the read data with only the selected bit replaced by `req_wdata[0]`. The response data of a write is zero.
- R5: If the downstream read completes with an error, the response has `rsp_error` = 1 and no write-back is issued.
- R6: If the write-back completes with an error, the response has `rsp_error` = 1.
- R7: A request whose size is not 1, 2 or 4 gets an error response in the cycle right after it is accepted, and no downstream access is made.
- R8: `req_ready` is high only in IDLE, so it is low from acceptance until the response cycle has ended. `rsp_valid` lasts exactly one cycle. It comes in the cycle after the edge that samples the final downstream `mem_done`.
- R9: During and right after reset, `req_ready` = 1, `rsp_valid` = 0 and `mem_req` = 0.
- R10: Downstream data lies in the low N bytes of the data word, little-endian, with the lowest-addressed byte in bits 7:0. The selected bit sits at bit position ((address >> 2) AND (8*size - 1)) of that data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge can accept a request (IDLE) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Alias address |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data; bit 0 is the bit value |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_error | output | 1 | Response status, 1 = error |
| rsp_rdata | output | 32 | Read result (bit 0 only) |
| mem_req | output | 1 | Downstream access request |
| mem_write | output | 1 | Downstream access is a write |
| mem_addr | output | 32 | Downstream byte address |
| mem_size | output | 3 | Downstream size in bytes |
| mem_wdata | output | 32 | Downstream write data |
| mem_done | input | 1 | Downstream access completed |
| mem_error | input | 1 | Downstream completion status |
| mem_rdata | input | 32 | Downstream read data |

## Verification
The bench memory model raises `mem_done` one cycle after it sees `mem_req`. With that model a read response is due two cycles after the acceptance edge and a write response four cycles after it. An illegal size is answered in the cycle right after acceptance. After each acceptance edge the bench counts cycles at falling edges until `rsp_valid` appears. It compares that count with the latency due, and it checks that `req_ready` stays low while it waits. Downstream address, size and traffic counts are recorded by the memory model and compared once the response arrives.

// File: rtl/bb_pkg.sv
package bb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WBACK = 2'd2,
        ST_RESP  = 2'd3
    } bb_state_e;
endpackage

// File: rtl/bb_xlate.sv
// Alias address to target address, bit index and size legality.
module bb_xlate #(
    parameter int ADDR_W  = 32,
    parameter int SIZE_W  = 3,
    parameter int WIN_W   = 25,
    parameter int WORD_SH = 5,
    parameter int SEL_BIT = 30,
    parameter int NUM_WIN = 2,
    parameter int IDX_W   = 5,
    parameter logic [NUM_WIN*ADDR_W-1:0] BASES = {32'h4000_0000, 32'h2000_0000}
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [IDX_W-1:0]  bit_idx,
    output logic              size_ok
);
    localparam int SEL_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
    localparam int BSH   = WORD_SH - 3;

    logic [ADDR_W-1:0] base_w [NUM_WIN];
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_base
        assign base_w[w] = BASES[w*ADDR_W +: ADDR_W];
    end

    logic [SEL_W-1:0]  win;
    logic [ADDR_W-1:0] off_ext;
    logic [ADDR_W-1:0] unal;
    logic [IDX_W-1:0]  idx_mask;
    logic              unused_addr_bits;

    assign win              = addr[SEL_BIT +: SEL_W];
    assign off_ext          = ADDR_W'(addr[WIN_W-1:0]) >> WORD_SH;
    assign unal             = base_w[win] | off_ext;
    assign unused_addr_bits = ^addr[ADDR_W-1:WIN_W];

    always_comb begin
        size_ok  = 1'b1;
        idx_mask = '0;
        unique case (size)
            SIZE_W'(1): idx_mask = IDX_W'(7);
            SIZE_W'(2): idx_mask = IDX_W'(15);
            SIZE_W'(4): idx_mask = IDX_W'(31);
            default:    size_ok  = 1'b0;
        endcase
    end

    assign tgt_addr = unal & ~(ADDR_W'(size) - ADDR_W'(1));
    assign bit_idx  = addr[BSH +: IDX_W] & idx_mask;
endmodule

// File: rtl/bb_rmw.sv
// Bit extraction and bit replacement in the fetched data.
module bb_rmw #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5
) (
    input  logic [DATA_W-1:0] rd_data,
    input  logic [IDX_W-1:0]  idx,
    input  logic              set_val,
    output logic [DATA_W-1:0] merged,
    output logic              sel_bit
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign merged[i] = (idx == IDX_W'(i)) ? set_val : rd_data[i];
    end
    assign sel_bit = rd_data[idx];
endmodule

// File: rtl/bb_seq.sv
// Sequencer: IDLE -> READ -> (WBACK) -> RESP -> IDLE.
module bb_seq
    import bb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic size_ok,
    input  logic wr_q,
    input  logic mem_done,
    input  logic mem_error,
    output logic req_ready,
    output logic mem_req,
    output logic mem_write,
    output logic rsp_valid,
    output logic rsp_error,
    output logic cap_req,
    output logic cap_rd
);
    bb_state_e state, state_nx;
    logic      err_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            rsp_error <= 1'b0;
        end else begin
            state     <= state_nx;
            rsp_error <= err_nx;
        end
    end

    always_comb begin
        state_nx  = state;
        err_nx    = rsp_error;
        req_ready = 1'b0;
        mem_req   = 1'b0;
        mem_write = 1'b0;
        rsp_valid = 1'b0;
        cap_req   = 1'b0;
        cap_rd    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    cap_req  = 1'b1;
                    err_nx   = !size_ok;
                    state_nx = size_ok ? ST_READ : ST_RESP;
                end
            end
            ST_READ: begin
                mem_req = 1'b1;
                if (mem_done) begin
                    cap_rd = 1'b1;
                    err_nx = mem_error;
                    if (mem_error || !wr_q) state_nx = ST_RESP;
                    else                    state_nx = ST_WBACK;
                end
            end
            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_write = 1'b1;
                if (mem_done) begin
                    err_nx   = mem_error;
                    state_nx = ST_RESP;
                end
            end
            ST_RESP: begin
                rsp_valid = 1'b1;
                state_nx  = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // R8: no request accepted while a downstream access is open
    a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);
    // R8: response is a single-cycle strobe
    a_r8_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R5: read error ends the access without a write-back
    a_r5_no_wb_on_rd_err: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_write && mem_done && mem_error) |=> (!mem_req && rsp_valid && rsp_error));
    // R6: write-back error reported
    a_r6_wb_err: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_write && mem_done && mem_error) |=> (rsp_valid && rsp_error));
    // R7: bad size answered at once, no downstream traffic
    a_r7_bad_size: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !size_ok) |=> (rsp_valid && rsp_error && !mem_req));
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int SIZE_W  = 3,
    parameter int WIN_W   = 25,
    parameter int WORD_SH = 5,
    parameter int SEL_BIT = 30,
    parameter int NUM_WIN = 2,
    parameter logic [NUM_WIN*ADDR_W-1:0] BASES = {32'h4000_0000, 32'h2000_0000}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_error,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_req,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [SIZE_W-1:0] mem_size,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_done,
    input  logic              mem_error,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int IDX_W = $clog2(DATA_W);

    logic [ADDR_W-1:0] tgt_c;
    logic [IDX_W-1:0]  idx_c;
    logic              size_ok;
    logic [ADDR_W-1:0] tgt_q;
    logic [SIZE_W-1:0] size_q;
    logic [IDX_W-1:0]  idx_q;
    logic              wr_q, set_q, rbit_q;
    logic [DATA_W-1:0] merged_c, wb_q;
    logic              sel_c;
    logic              cap_req, cap_rd;
    logic              unused_wdata;

    assign unused_wdata = ^req_wdata[DATA_W-1:1];

    bb_xlate #(
        .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .WIN_W(WIN_W), .WORD_SH(WORD_SH),
        .SEL_BIT(SEL_BIT), .NUM_WIN(NUM_WIN), .IDX_W(IDX_W), .BASES(BASES)
    ) xlate_i (
        .addr(req_addr), .size(req_size),
        .tgt_addr(tgt_c), .bit_idx(idx_c), .size_ok(size_ok)
    );

    bb_rmw #(.DATA_W(DATA_W), .IDX_W(IDX_W)) rmw_i (
        .rd_data(mem_rdata), .idx(idx_q), .set_val(set_q),
        .merged(merged_c), .sel_bit(sel_c)
    );

    bb_seq seq_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .size_ok(size_ok),
        .wr_q(wr_q), .mem_done(mem_done), .mem_error(mem_error),
        .req_ready(req_ready), .mem_req(mem_req), .mem_write(mem_write),
        .rsp_valid(rsp_valid), .rsp_error(rsp_error),
        .cap_req(cap_req), .cap_rd(cap_rd)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q  <= '0;
            size_q <= '0;
            idx_q  <= '0;
            wr_q   <= 1'b0;
            set_q  <= 1'b0;
            rbit_q <= 1'b0;
            wb_q   <= '0;
        end else begin
            if (cap_req) begin
                tgt_q  <= tgt_c;
                size_q <= req_size;
                idx_q  <= idx_c;
                wr_q   <= req_write;
                set_q  <= req_wdata[0];
                rbit_q <= 1'b0;
            end
            if (cap_rd) begin
                wb_q <= merged_c;
                if (!wr_q) rbit_q <= sel_c;
            end
        end
    end

    assign mem_addr  = tgt_q;
    assign mem_size  = size_q;
    assign mem_wdata = mem_write ? wb_q : '0;
    assign rsp_rdata = {{(DATA_W-1){1'b0}}, rbit_q};

    // R3: only bit 0 of a response may be set
    a_r3_bit_only: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_rdata[DATA_W-1:1] == '0));
    // R4: address and size held while an access is open
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_done) |=> ($stable(mem_addr) && $stable(mem_size)));
    // R4: write-back follows a clean read of a write, same address
    a_r4_wb_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_write && mem_done && !mem_error && wr_q) |=> (mem_req && mem_write && $stable(mem_addr)));
endmodule

// File: tb/bitband_bridge_tb_top.sv
module bitband_bridge_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic [2:0]  req_size = '0;
    logic        req_ready, rsp_valid, rsp_error;
    logic [31:0] rsp_rdata;
    logic        mem_req, mem_write;
    logic [31:0] mem_addr, mem_wdata;
    logic [2:0]  mem_size;
    logic        mem_done = 1'b0, mem_error = 1'b0;
    logic [31:0] mem_rdata = '0;

    int errors = 0, checks = 0;
    logic finished = 1'b0;

    always #4 clk = ~clk;

    bitband_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_error(rsp_error),
        .rsp_rdata(rsp_rdata), .mem_req(mem_req), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
        .mem_done(mem_done), .mem_error(mem_error), .mem_rdata(mem_rdata)
    );

    // Memory model: 256 bytes, completes one cycle after seeing a request.
    logic [7:0]  mem [256];
    logic [7:0]  ref_mem [256];
    logic        inj_rd = 1'b0, inj_wr = 1'b0;
    int          rd_cnt = 0, wr_cnt = 0;
    logic [31:0] last_rd_addr = '0, last_wr_addr = '0;
    logic [2:0]  last_rd_size = '0, last_wr_size = '0;

    function automatic logic [7:0] mi(input logic [31:0] a);
        return {a[30], a[6:0]};
    endfunction

    function automatic logic [31:0] rd_word(input logic [31:0] a, input logic [2:0] s);
        logic [31:0] w = '0;
        for (int k = 0; k < 4; k++)
            if (k < int'(s)) w[8*k +: 8] = mem[mi(a + 32'(k))];
        return w;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_done <= 1'b0;
        end else if (mem_done) begin
            mem_done <= 1'b0;
        end else if (mem_req) begin
            mem_done <= 1'b1;
            if (mem_write) begin
                wr_cnt       <= wr_cnt + 1;
                last_wr_addr <= mem_addr;
                last_wr_size <= mem_size;
                mem_error    <= inj_wr;
                if (!inj_wr)
                    for (int k = 0; k < 4; k++)
                        if (k < int'(mem_size)) mem[mi(mem_addr + 32'(k))] = mem_wdata[8*k +: 8];
            end else begin
                rd_cnt       <= rd_cnt + 1;
                last_rd_addr <= mem_addr;
                last_rd_size <= mem_size;
                mem_error    <= inj_rd;
                mem_rdata    <= rd_word(mem_addr, mem_size);
            end
        end
    end

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] byte_of(input logic [31:0] a);
        return (a[30] ? 32'h4000_0000 : 32'h2000_0000) | {7'b0, a[24:5]};
    endfunction

    function automatic int mem_diffs();
        int n = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) n++;
        return n;
    endfunction

    task automatic access(input logic wr, input logic [31:0] a, input logic [2:0] sz,
                          input logic [31:0] wd, output logic [31:0] rd,
                          output logic er, output int lat, output logic rdy_ok);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0; rdy_ok = 1'b1;
        while (!rsp_valid && lat < 50) begin
            if (req_ready) rdy_ok = 1'b0;
            @(negedge clk);
            lat++;
        end
        rd = rsp_rdata; er = rsp_error;
    endtask

    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic [2:0]  size;
        logic [31:0] wdata;
        logic [31:0] maddr;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'h2200_0000, 3'd4, 32'h0,         32'h2000_0000},
        '{1'b0, 32'h2200_00FC, 3'd4, 32'h0,         32'h2000_0004},
        '{1'b0, 32'h4200_0024, 3'd1, 32'h0,         32'h4000_0001},
        '{1'b0, 32'h4200_0044, 3'd2, 32'h0,         32'h4000_0002},
        '{1'b0, 32'h2200_0064, 3'd2, 32'h0,         32'h2000_0002},
        '{1'b0, 32'h23FF_FFFC, 3'd1, 32'h0,         32'h200F_FFFF},
        '{1'b1, 32'h2200_00FC, 3'd4, 32'h0000_0001, 32'h2000_0004},
        '{1'b1, 32'h4200_0024, 3'd1, 32'h0000_0000, 32'h4000_0001},
        '{1'b1, 32'h2200_0060, 3'd2, 32'hFFFF_FFFE, 32'h2000_0002},
        '{1'b1, 32'h4200_0044, 3'd2, 32'h0000_0001, 32'h4000_0002},
        '{1'b0, 32'h2200_00FC, 3'd4, 32'h0,         32'h2000_0004}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd, b;
        logic        er, rdy, expb;
        int          lat, r0, w0;

        for (int i = 0; i < 256; i++) begin
            mem[i]     = 8'h5A ^ 8'(i);
            ref_mem[i] = 8'h5A ^ 8'(i);
        end

        repeat (3) @(negedge clk);
        check(req_ready === 1'b1, "R9 ready in reset", 32'(req_ready), 32'd1);
        check(rsp_valid === 1'b0 && mem_req === 1'b0, "R9 idle outputs in reset",
              {30'd0, rsp_valid, mem_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready === 1'b1 && mem_req === 1'b0 && rsp_valid === 1'b0, "R9 after reset",
              {29'd0, req_ready, mem_req, rsp_valid}, 32'd4);

        for (int v = 0; v < NV; v++) begin
            r0 = rd_cnt; w0 = wr_cnt;
            b = byte_of(VECS[v].addr);
            expb = ref_mem[mi(b)][VECS[v].addr[4:2]];
            access(VECS[v].wr, VECS[v].addr, VECS[v].size, VECS[v].wdata, rd, er, lat, rdy);
            check(last_rd_addr === VECS[v].maddr, "R1 downstream address", last_rd_addr, VECS[v].maddr);
            check(last_rd_size === VECS[v].size, "R2 downstream size", 32'(last_rd_size), 32'(VECS[v].size));
            check(er === 1'b0, "R3/R4 no error", 32'(er), 32'd0);
            check(rdy === 1'b1, "R8 ready low while busy", 32'(rdy), 32'd1);
            if (!VECS[v].wr) begin
                check(rd === {31'd0, expb}, "R3 R10 read bit", rd, {31'd0, expb});
                check(lat == 2, "R8 read latency", 32'(lat), 32'd2);
                check(rd_cnt == r0 + 1 && wr_cnt == w0, "R3 single read no write",
                      32'(wr_cnt - w0), 32'd0);
            end else begin
                ref_mem[mi(b)][VECS[v].addr[4:2]] = VECS[v].wdata[0];
                check(last_wr_addr === VECS[v].maddr && last_wr_size === VECS[v].size,
                      "R4 write-back address", last_wr_addr, VECS[v].maddr);
                check(mem_diffs() == 0, "R4 R10 memory after write", 32'(mem_diffs()), 32'd0);
                check(rd === 32'd0, "R4 write response data", rd, 32'd0);
                check(lat == 4, "R8 write latency", 32'(lat), 32'd4);
            end
        end

        // R5: read error during a write
        inj_rd = 1'b1; w0 = wr_cnt;
        access(1'b1, 32'h2200_0000, 3'd4, 32'h1, rd, er, lat, rdy);
        check(er === 1'b1, "R5 error returned", 32'(er), 32'd1);
        check(wr_cnt == w0 && mem_diffs() == 0, "R5 no write-back", 32'(wr_cnt - w0), 32'd0);
        check(lat == 2, "R5 latency", 32'(lat), 32'd2);
        access(1'b0, 32'h4200_0000, 3'd1, 32'h0, rd, er, lat, rdy);
        check(er === 1'b1, "R5 read error on read", 32'(er), 32'd1);
        inj_rd = 1'b0;

        // R6: write-back error
        inj_wr = 1'b1; w0 = wr_cnt;
        access(1'b1, 32'h2200_0004, 3'd1, 32'h1, rd, er, lat, rdy);
        check(er === 1'b1, "R6 write-back error", 32'(er), 32'd1);
        check(wr_cnt == w0 + 1, "R6 write-back issued", 32'(wr_cnt - w0), 32'd1);
        check(lat == 4, "R6 latency", 32'(lat), 32'd4);
        inj_wr = 1'b0;

        // R7: illegal sizes
        for (int s = 0; s < 2; s++) begin
            r0 = rd_cnt; w0 = wr_cnt;
            access(1'b1, 32'h2200_0010, (s == 0) ? 3'd3 : 3'd0, 32'h1, rd, er, lat, rdy);
            check(er === 1'b1, "R7 illegal size error", 32'(er), 32'd1);
            check(rd_cnt == r0 && wr_cnt == w0, "R7 no downstream traffic",
                  32'(rd_cnt - r0 + wr_cnt - w0), 32'd0);
            check(lat == 0, "R7 immediate response", 32'(lat), 32'd0);
        end

        // R8: pulse length, back to idle
        @(negedge clk);
        check(rsp_valid === 1'b0 && req_ready === 1'b1, "R8 single-cycle response",
              {30'd0, rsp_valid, req_ready}, 32'd1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule